// File: doc/BRIEF.md
# Sensor Register Two-Wire Slave with Broadcast Access

This block is a slave-only two-wire serial port for a small temperature-sensor register file. SCL and SDA are sampled in the system clock domain, and SDA is driven as an open-drain pull-down. The block recognises START and STOP, its own strapped 7-bit address, a broadcast write address, a broadcast read address and a general-call reset. It ignores a high-speed master code, but it records that the code was seen.

The register file holds a 2-bit pointer and four byte registers: a read-only temperature, a configuration byte, a low limit and a high limit. The sensor side loads the temperature with a strobe. The host side sees the writable registers, the pointer, and one-cycle strobes that mark each register write and each register value loaded for transmission.

Several instances with different strap values can share one bus. In a broadcast read, every instance counts the byte slots and drives only the slot equal to its strap index. This lets a master collect all readings in one transfer.

Top module: `tsense_i2c_slave`

## Requirements
- R1: The device address is binary 1110 followed by the 3-bit strap, giving 0x70 to 0x77. The device acknowledges its own address in both directions and never acknowledges another 7-bit address.
- R2: The first byte after a write address is the pointer. A pointer byte with bits 7..2 all zero is acknowledged, and its bits 1..0 select temperature (00), configuration (01), low limit (10) or high limit (11). Any other pointer byte is not acknowledged and leaves the pointer unchanged.
- R3: The pointer resets to 00 and holds its value until the next pointer byte or reset. A read that has no pointer byte before it returns the register the pointer selects.
- R4: After reset, temperature reads 0x00, configuration 0x02, low limit 0xF6 (-10) and high limit 0x3C (+60). SDA is released and the high-speed flag is clear.
- R5: A data byte after the pointer is acknowledged. It updates the selected register only once all eight bits have arrived, so a transfer stopped mid-byte changes nothing. A bus write to the temperature register has no effect.
- R6: The broadcast write address 0x00, followed by a pointer byte 0x00 to 0x03 and a data byte, is acknowledged at every byte. It sets the pointer and writes the register exactly as an addressed write does.
- R7: The broadcast read address 0x01 is acknowledged. The device with strap k then transmits the selected register in data slot k (counting from 0) and leaves every other slot high. After the master answers any slot with NACK, the device drives no further slot.
- R8: The general call 0x00 followed by 0x06 is acknowledged at both bytes. It returns all four registers and the pointer to their reset values.
- R9: After a 0x00 address byte, a second byte that is neither 0x06 nor in the range 0x00 to 0x03 is not acknowledged and changes nothing.
- R10: A first byte of the form 00001xxx is not acknowledged. It raises hsMode, which stays high across repeated STARTs and clears at the next STOP.
- R11: If SCL stays low for TIMEOUT_CYCLES system clocks during a transfer, the device releases SDA and ignores the bus until a new START.
- R12: Bytes are shifted in and out MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strap | input | 3 | Device index, low three address bits |
| sclIn | input | 1 | Bus clock as seen on the wire |
| sdaIn | input | 1 | Bus data as seen on the wire |
| tempLoad | input | 1 | Strobe to capture a new temperature |
| tempValue | input | 8 | Two's complement temperature, 1 degree per count |
| sdaPullLow | output | 1 | 1 pulls SDA low; 0 releases it |
| hsMode | output | 1 | High-speed master code seen since the last STOP |
| busWrite | output | 1 | One-cycle pulse when a bus write lands |
| busRead | output | 1 | One-cycle pulse when a value is loaded for transmission |
| ptrValue | output | 2 | Current register pointer |
| cfgValue | output | 8 | Configuration register |
| lowLimit | output | 8 | Low limit register |
| highLimit | output | 8 | High limit register |

## Verification
The broadcast read is swept over all eight strap values, with eight slots read in each pass. This tells a device that answers in the wrong slot apart from one that answers in several slots or in none. The address decode is swept over all eight addresses in the device's block, so an ignored strap bit shows up. A second broadcast read has the master NACK an early slot that belongs to another device; it separates "stop driving after any NACK" from "stop only after your own slot". Further patterns cover a partial data byte, a bad pointer, a bad second broadcast byte, the master code across a repeated START, and an SCL hold beyond the timeout. Each of these separates acceptance from rejection at the ACK bit and at the register outputs.

// File: rtl/tsense_i2c_pkg.sv
package tsense_i2c_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 4;
  localparam int PTR_W    = $clog2(NUM_REGS);

  localparam logic [PTR_W-1:0] REG_TEMP = '0;

  localparam logic [BYTE_W-1:0] BC_WR_ADDR   = 8'h00;
  localparam logic [BYTE_W-1:0] BC_RD_ADDR   = 8'h01;
  localparam logic [BYTE_W-1:0] GC_RESET_CMD = 8'h06;
  localparam logic [4:0]        HS_PREFIX    = 5'b00001;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_PTR, PH_BCMD, PH_WDATA, PH_READ, PH_IGNORE
  } phase_t;

  typedef struct packed {
    logic              ptrWe;
    logic [PTR_W-1:0]  ptrVal;
    logic              dataWe;
    logic [BYTE_W-1:0] dataVal;
    logic              genReset;
    logic              rdLoad;
  } regStrobe_t;
endpackage

// File: rtl/tsense_regfile.sv
module tsense_regfile
  import tsense_i2c_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CFG_INIT  = 8'h02,
  parameter logic [BYTE_W-1:0] LOW_INIT  = 8'hF6,
  parameter logic [BYTE_W-1:0] HIGH_INIT = 8'h3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic              tempLoad,
  input  logic [BYTE_W-1:0] tempValue,
  output logic [BYTE_W-1:0] rdData,
  output logic [PTR_W-1:0]  ptrValue,
  output logic [BYTE_W-1:0] cfgValue,
  output logic [BYTE_W-1:0] lowLimit,
  output logic [BYTE_W-1:0] highLimit,
  output logic              busWrite,
  output logic              busRead
);
  logic [NUM_REGS-1:0][BYTE_W-1:0] regBank;
  logic [PTR_W-1:0] ptr;

  function automatic logic [BYTE_W-1:0] initVal(input int idx);
    case (idx)
      1:       return CFG_INIT;
      2:       return LOW_INIT;
      3:       return HIGH_INIT;
      default: return '0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regBank[i] <= initVal(i);
      ptr <= '0;
    end else if (strobe.genReset) begin
      for (int i = 0; i < NUM_REGS; i++) regBank[i] <= initVal(i);
      ptr <= '0;
    end else begin
      if (tempLoad) regBank[REG_TEMP] <= tempValue;
      // temperature is read-only from the bus
      if (strobe.dataWe && ptr != REG_TEMP) regBank[ptr] <= strobe.dataVal;
      if (strobe.ptrWe) ptr <= strobe.ptrVal;
    end
  end

  assign rdData    = regBank[ptr];
  assign ptrValue  = ptr;
  assign cfgValue  = regBank[1];
  assign lowLimit  = regBank[2];
  assign highLimit = regBank[3];
  assign busWrite  = strobe.dataWe;
  assign busRead   = strobe.rdLoad;

  a_r5_temp_readonly: assert property (@(posedge clk) disable iff (!rstN)
    (!tempLoad && !strobe.genReset) |=> $stable(regBank[REG_TEMP]));

  a_r3_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.ptrWe && !strobe.genReset) |=> $stable(ptr));

  a_r8_reset_values: assert property (@(posedge clk) disable iff (!rstN)
    strobe.genReset |=> (ptr == '0 && regBank[1] == CFG_INIT &&
                         regBank[2] == LOW_INIT && regBank[3] == HIGH_INIT));
endmodule

// File: rtl/tsense_i2c_ctrl.sv
module tsense_i2c_ctrl
  import tsense_i2c_pkg::*;
#(
  parameter int         TIMEOUT_CYCLES = 1500000,
  parameter int         STRAP_W        = 3,
  parameter logic [3:0] ADDR_HI        = 4'b1110
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STRAP_W-1:0] strap,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [BYTE_W-1:0]  rdData,
  output regStrobe_t         strobe,
  output logic               sdaPullLow,
  output logic               hsMode
);
  localparam int TO_W   = $clog2(TIMEOUT_CYCLES + 1);
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam int SLOT_W = STRAP_W + 1;
  localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(BYTE_W);
  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

  logic [1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev, sclS, sdaS;
  logic sclRise, sclFall, startDet, stopDet, timeoutHit;

  phase_t phase, phDec;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] rxShift, txShift;
  logic [SLOT_W-1:0] slotCnt, slotNext;
  logic [TO_W-1:0]   toCnt;
  logic devAckBit, hostAckBit, ackDrive, txActive, bcastRd;
  logic isRx, byteDone, ackDec, bcDec, hsSet, ptrWeD, dataWeD, genRstD;
  logic txLoadNow, txActNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11; sdaSync <= 2'b11; sclPrev <= 1'b1; sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclS     = sclSync[1];
  assign sdaS     = sdaSync[1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) toCnt <= '0;
    else if (sclS || phase == PH_IDLE) toCnt <= '0;
    else if (toCnt != TO_W'(TIMEOUT_CYCLES - 1)) toCnt <= toCnt + 1'b1;
  end
  assign timeoutHit = !sclS && phase != PH_IDLE && toCnt == TO_W'(TIMEOUT_CYCLES - 1);

  assign isRx = phase inside {PH_ADDR, PH_PTR, PH_BCMD, PH_WDATA};
  assign byteDone = sclFall && !devAckBit && bitCnt == FULL_CNT && isRx;

  always_comb begin
    ackDec = 1'b0; phDec = PH_IGNORE; bcDec = 1'b0; hsSet = 1'b0;
    ptrWeD = 1'b0; dataWeD = 1'b0; genRstD = 1'b0;
    case (phase)
      PH_ADDR: begin
        if (rxShift[BYTE_W-1:1] == {ADDR_HI, strap}) begin
          ackDec = 1'b1;
          phDec  = rxShift[0] ? PH_READ : PH_PTR;
        end else if (rxShift == BC_WR_ADDR) begin
          ackDec = 1'b1; phDec = PH_BCMD;
        end else if (rxShift == BC_RD_ADDR) begin
          ackDec = 1'b1; phDec = PH_READ; bcDec = 1'b1;
        end else if (rxShift[BYTE_W-1:3] == HS_PREFIX) begin
          hsSet = 1'b1;
        end
      end
      PH_PTR: if (rxShift[BYTE_W-1:PTR_W] == '0) begin
        ackDec = 1'b1; phDec = PH_WDATA; ptrWeD = 1'b1;
      end
      PH_BCMD: begin
        if (rxShift == GC_RESET_CMD) begin
          ackDec = 1'b1; genRstD = 1'b1;
        end else if (rxShift[BYTE_W-1:PTR_W] == '0) begin
          ackDec = 1'b1; phDec = PH_WDATA; ptrWeD = 1'b1;
        end
      end
      PH_WDATA: begin
        ackDec = 1'b1; dataWeD = 1'b1;
      end
      default: ;
    endcase
  end

  // slot bookkeeping for transmit; saturates so it never wraps onto a strap
  assign slotNext  = devAckBit ? '0 : (slotCnt == SLOT_MAX ? slotCnt : slotCnt + 1'b1);
  assign txActNext = bcastRd ? (slotNext == {1'b0, strap}) : 1'b1;
  assign txLoadNow = sclFall && (devAckBit || hostAckBit) && phase == PH_READ;

  assign strobe.ptrWe    = byteDone && ptrWeD;
  assign strobe.ptrVal   = rxShift[PTR_W-1:0];
  assign strobe.dataWe   = byteDone && dataWeD;
  assign strobe.dataVal  = rxShift;
  assign strobe.genReset = byteDone && genRstD;
  assign strobe.rdLoad   = txLoadNow && txActNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE; bitCnt <= '0; rxShift <= '0; txShift <= '0;
      slotCnt <= '0; devAckBit <= 1'b0; hostAckBit <= 1'b0; ackDrive <= 1'b0;
      txActive <= 1'b0; bcastRd <= 1'b0; hsMode <= 1'b0;
    end else if (startDet) begin
      phase <= PH_ADDR; bitCnt <= '0; devAckBit <= 1'b0; hostAckBit <= 1'b0;
      ackDrive <= 1'b0; txActive <= 1'b0; bcastRd <= 1'b0;
    end else if (stopDet || timeoutHit) begin
      phase <= PH_IDLE; bitCnt <= '0; devAckBit <= 1'b0; hostAckBit <= 1'b0;
      ackDrive <= 1'b0; txActive <= 1'b0; bcastRd <= 1'b0;
      if (stopDet) hsMode <= 1'b0;
    end else begin
      if (sclRise && !devAckBit && !hostAckBit && bitCnt < FULL_CNT &&
          (isRx || phase == PH_READ)) begin
        bitCnt <= bitCnt + 1'b1;
        if (isRx) rxShift <= {rxShift[BYTE_W-2:0], sdaS};
      end
      if (sclRise && hostAckBit && sdaS) begin
        phase <= PH_IGNORE; txActive <= 1'b0;
      end
      if (byteDone) begin
        if (ackDec) begin devAckBit <= 1'b1; ackDrive <= 1'b1; end
        phase   <= ackDec ? phDec : PH_IGNORE;
        bcastRd <= bcDec;
        if (hsSet) hsMode <= 1'b1;
      end
      if (sclFall && devAckBit) begin
        devAckBit <= 1'b0; ackDrive <= 1'b0; bitCnt <= '0;
        if (phase == PH_READ) begin
          slotCnt <= slotNext; txActive <= txActNext; txShift <= rdData;
        end
      end
      if (sclFall && !devAckBit && !hostAckBit && phase == PH_READ) begin
        if (bitCnt == FULL_CNT) hostAckBit <= 1'b1;
        else if (bitCnt != '0) txShift <= {txShift[BYTE_W-2:0], 1'b0};
      end
      if (sclFall && hostAckBit) begin
        hostAckBit <= 1'b0; bitCnt <= '0; slotCnt <= slotNext;
        if (phase == PH_READ) begin
          txActive <= txActNext; txShift <= rdData;
        end
      end
    end
  end

  assign sdaPullLow = ackDrive |
                      (txActive && phase == PH_READ && !hostAckBit && !devAckBit &&
                       !txShift[BYTE_W-1]);

  a_r11_idle_release: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE) |-> !sdaPullLow);

  a_r7_slot_owner: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_READ && bcastRd && txActive) |-> slotCnt == {1'b0, strap});

  a_r7_silent_after_nack: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IGNORE && !devAckBit) |-> !sdaPullLow);

  a_r10_hs_until_stop: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !hsMode);
endmodule

// File: rtl/tsense_i2c_slave.sv
module tsense_i2c_slave
  import tsense_i2c_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        strap,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              tempLoad,
  input  logic [BYTE_W-1:0] tempValue,
  output logic              sdaPullLow,
  output logic              hsMode,
  output logic              busWrite,
  output logic              busRead,
  output logic [PTR_W-1:0]  ptrValue,
  output logic [BYTE_W-1:0] cfgValue,
  output logic [BYTE_W-1:0] lowLimit,
  output logic [BYTE_W-1:0] highLimit
);
  regStrobe_t        strobe;
  logic [BYTE_W-1:0] rdData;

  tsense_i2c_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES), .STRAP_W(3)) u_ctrl (
    .clk(clk), .rstN(rstN), .strap(strap), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdData(rdData), .strobe(strobe), .sdaPullLow(sdaPullLow), .hsMode(hsMode)
  );

  tsense_regfile u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tempLoad(tempLoad),
    .tempValue(tempValue), .rdData(rdData), .ptrValue(ptrValue),
    .cfgValue(cfgValue), .lowLimit(lowLimit), .highLimit(highLimit),
    .busWrite(busWrite), .busRead(busRead)
  );
endmodule

// File: tb/test_tsense_i2c_slave.sv
module test_tsense_i2c_slave;
  logic clk = 1'b0;
  logic rstN;
  logic [2:0] strap;
  logic sclM, sdaM, tempLoad;
  logic [7:0] tempValue;
  logic sdaPullLow, hsMode, busWrite, busRead;
  logic [1:0] ptrValue;
  logic [7:0] cfgValue, lowLimit, highLimit;
  logic sdaLine;
  int checks = 0;
  int fails = 0;
  logic ackBit;
  logic [7:0] rdByte;

  always #10 clk = ~clk;
  assign sdaLine = sdaM & ~sdaPullLow;

  tsense_i2c_slave #(.TIMEOUT_CYCLES(400)) i_tsense_i2c_slave (
    .clk(clk), .rstN(rstN), .strap(strap), .sclIn(sclM), .sdaIn(sdaLine),
    .tempLoad(tempLoad), .tempValue(tempValue), .sdaPullLow(sdaPullLow),
    .hsMode(hsMode), .busWrite(busWrite), .busRead(busRead),
    .ptrValue(ptrValue), .cfgValue(cfgValue), .lowLimit(lowLimit),
    .highLimit(highLimit)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(5); sclM = 1'b1; tick(5); sdaM = 1'b0; tick(5); sclM = 1'b0; tick(5);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(5); sclM = 1'b1; tick(5); sdaM = 1'b1; tick(5);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; tick(5); sclM = 1'b1; tick(10); sclM = 1'b0; tick(5);
  endtask

  task automatic getBit(output logic b);
    sdaM = 1'b1; tick(5); sclM = 1'b1; tick(5); b = sdaLine; tick(5); sclM = 1'b0; tick(5);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic raw;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    getBit(raw);
    ack = ~raw;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      v[i] = b;
    end
    sendBit(~ackIt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    sclM = 1'b1; sdaM = 1'b1; strap = 3'd3; tempLoad = 1'b0; tempValue = 8'h00;
    rstN = 1'b0; tick(5); rstN = 1'b1; tick(5);

    chk("R4 sda released", sdaPullLow, 0);
    chk("R4 cfg reset", cfgValue, 8'h02);
    chk("R4 low reset", lowLimit, 8'hF6);
    chk("R4 high reset", highLimit, 8'h3C);
    chk("R4 pointer reset", ptrValue, 0);
    chk("R4 hsMode reset", hsMode, 0);

    tempValue = 8'h19; tempLoad = 1'b1; tick(1); tempLoad = 1'b0;

    // R3 R12: read with no pointer write returns temperature, MSB first
    busStart(); sendByte(8'hE7, ackBit); chk("R1 read address ack", ackBit, 1);
    recvByte(1'b0, rdByte); chk("R3 R12 default pointer read", rdByte, 8'h19); busStop();

    // R1 sweep of the 0x70..0x77 block, only strap 3 answers
    for (int a = 0; a < 8; a++) begin
      busStart(); sendByte(8'(((8'h70 | a) << 1) | 1), ackBit);
      chk("R1 address sweep", ackBit, (a == 3) ? 1 : 0);
      if (ackBit) recvByte(1'b0, rdByte);
      busStop();
    end

    // R2 R5 addressed write of configuration
    busStart(); sendByte(8'hE6, ackBit); chk("R1 write address ack", ackBit, 1);
    sendByte(8'h01, ackBit); chk("R2 pointer ack", ackBit, 1);
    sendByte(8'hA5, ackBit); chk("R5 data ack", ackBit, 1); busStop();
    chk("R5 cfg written", cfgValue, 8'hA5);
    chk("R2 pointer selects cfg", ptrValue, 1);

    busStart(); sendByte(8'hE7, ackBit); recvByte(1'b0, rdByte);
    chk("R3 pointer persists", rdByte, 8'hA5); busStop();

    busStart(); sendByte(8'hE6, ackBit); sendByte(8'h05, ackBit);
    chk("R2 bad pointer nack", ackBit, 0); busStop();
    chk("R2 pointer unchanged", ptrValue, 1);

    busStart(); sendByte(8'hE8, ackBit); chk("R1 foreign address nack", ackBit, 0); busStop();

    // R5 temperature is read-only
    busStart(); sendByte(8'hE6, ackBit); sendByte(8'h00, ackBit);
    sendByte(8'h55, ackBit); chk("R5 temp write ack", ackBit, 1); busStop();
    busStart(); sendByte(8'hE7, ackBit); recvByte(1'b0, rdByte);
    chk("R5 temp unchanged", rdByte, 8'h19); busStop();

    // R5 partial byte must not write
    busStart(); sendByte(8'hE6, ackBit); sendByte(8'h02, ackBit);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b0); busStop();
    chk("R5 partial byte ignored", lowLimit, 8'hF6);

    // R6 broadcast write
    busStart(); sendByte(8'h00, ackBit); chk("R6 broadcast addr ack", ackBit, 1);
    sendByte(8'h03, ackBit); chk("R6 broadcast pointer ack", ackBit, 1);
    sendByte(8'h7E, ackBit); chk("R6 broadcast data ack", ackBit, 1); busStop();
    chk("R6 high limit written", highLimit, 8'h7E);
    chk("R6 pointer set", ptrValue, 3);

    // R7 broadcast read: sweep every strap over every slot
    for (int k = 0; k < 8; k++) begin
      strap = 3'(k); tick(5);
      busStart(); sendByte(8'h01, ackBit); chk("R7 broadcast read ack", ackBit, 1);
      for (int s = 0; s < 8; s++) begin
        recvByte(s != 7, rdByte);
        chk("R7 slot ownership", rdByte, (s == k) ? 8'h7E : 8'hFF);
      end
      busStop();
    end

    // R7 master NACK at slot 2 silences strap 5
    strap = 3'd5; tick(5);
    busStart(); sendByte(8'h01, ackBit);
    for (int s = 0; s < 8; s++) begin
      recvByte(s != 2, rdByte);
      chk("R7 silent after nack", rdByte, 8'hFF);
    end
    busStop();
    strap = 3'd3; tick(5);

    // R9 bad second broadcast byte
    busStart(); sendByte(8'h00, ackBit); sendByte(8'h09, ackBit);
    chk("R9 bad command nack", ackBit, 0); busStop();
    chk("R9 pointer unchanged", ptrValue, 3);

    // R8 general call reset
    busStart(); sendByte(8'h00, ackBit); sendByte(8'h06, ackBit);
    chk("R8 reset command ack", ackBit, 1); busStop();
    chk("R8 cfg restored", cfgValue, 8'h02);
    chk("R8 high restored", highLimit, 8'h3C);
    chk("R8 pointer restored", ptrValue, 0);
    busStart(); sendByte(8'hE7, ackBit); recvByte(1'b0, rdByte);
    chk("R8 temp restored", rdByte, 8'h00); busStop();

    // R10 master code
    busStart(); sendByte(8'h0A, ackBit); chk("R10 master code nack", ackBit, 0);
    chk("R10 hsMode set", hsMode, 1);
    busStart(); sendByte(8'hE7, ackBit); chk("R10 address after repeated start", ackBit, 1);
    recvByte(1'b0, rdByte); chk("R10 hsMode held", hsMode, 1); busStop(); tick(5);
    chk("R10 hsMode cleared by stop", hsMode, 0);

    // R11 SCL low timeout during the device's ACK
    busStart();
    for (int i = 7; i >= 0; i--) sendBit(8'hE6 >> i);
    tick(20); chk("R11 ack held before timeout", sdaPullLow, 1);
    tick(500); chk("R11 released after timeout", sdaPullLow, 0);
    sendByte(8'hE6, ackBit); chk("R11 waits for start", ackBit, 0); busStop();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule